// File: doc/BRIEF.md
# Interval Timer Register Access and Latch Controller

This block is the byte-wide register front end of a three-channel interval timer. A 2-bit address selects one of four ports. Ports 0, 1 and 2 carry count data for the matching channel, and port 3 takes control bytes. The control bytes do four things: they program a channel's operating mode and byte order, take a snapshot of a channel's count, and take snapshots of count and status across several channels in a single command. The block keeps a byte sequencer for each channel. For writes, the sequencer turns one or two data bytes into a count load. For reads, it returns latched status, latched count or live count, in that order of preference.

The counting engine sits outside this block. It receives a load strobe, a 16-bit start value, a mode and a BCD flag for each channel. It returns each channel's running count and its output level. A small auxiliary port sets channel 2's gate and a speaker-enable flag. Reading it returns those two bits, channel 2's output level and a free-running refresh bit.

Top module: `timer_bus_front`

## Requirements
- R1: On a write to port 3, bits 7:6 select channel 0, 1 or 2. The value 3 in that field marks a multi-channel read-back command.
- R2: A channel-select control byte with bits 5:4 non-zero programs that channel. Bits 5:4 become the byte order: 1 = low byte only, 2 = high byte only, 3 = low then high. Bits 3:1 become the mode, with codes 6 and 7 folded to 2 and 3. Bit 0 becomes the BCD flag. Channel n shows its mode on `chan_mode[3n+2:3n]` and its BCD flag on `chan_bcd[n]` from the next cycle.
- R3: A data write loads as follows. In low-only order it loads {8'h00, byte}. In high-only order it loads {byte, 8'h00}. In low-then-high order the first byte is held and the second loads {second, first}. Each completed load raises that channel's `load_pulse` bit for exactly one cycle, with the value on `load_val[16n+15:16n]`. Control writes never produce a load.
- R4: Programming a channel rewinds both of its byte sequencers. After programming, the next data write is taken as a low byte and the next live read returns a low byte, even if a word was half written or half read before.
- R5: A channel-select control byte with bits 5:4 equal to 0 snapshots that channel's live count. Reads then return the snapshot in the channel's byte order, low byte before high byte in word order, and after that the snapshot is released. A second latch command that arrives while a snapshot is still unread has no effect.
- R6: A read-back control byte (bits 7:6 = 3) acts on every channel n whose bit n+1 is set. When bit 5 is 0 it latches the count, and when bit 4 is 0 it latches the status. Channels whose bit is clear are untouched.
- R7: The status byte is {output, 0, byte order[1:0], mode[2:0], BCD}. It is captured when the command is written. A data read returns a pending status first, then a pending count snapshot, and only then the live count.
- R8: A live read with no snapshot pending works by byte order. Low-only returns the live low byte, high-only returns the live high byte, and low-then-high alternates low and high.
- R9: An auxiliary write sets channel 2's gate from bit 0 and the speaker flag from bit 1. An auxiliary read returns gate in bit 0, speaker in bit 1, refresh in bit 4 and channel 2's output in bit 5, with all other bits 0.
- R10: The refresh bit is 0 at reset and inverts every 2^REFRESH_LOG2 clock cycles.
- R11: While reset is held and in the first cycle after it, every channel's `load_pulse` is 1 and its `load_val` is 0. Reset leaves gates 0 and 1 high, gate 2 low, the speaker flag off, every channel in mode 0 with low-only order and BCD off, and no snapshot pending.
- R12: A read from port 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; side effects are applied at the clock edge |
| addr | input | 2 | Port select: 0..2 data, 3 control |
| wdata | input | BYTE_W | Write byte |
| rdata | output | BYTE_W | Read byte for the current address |
| live_count | input | 3*2*BYTE_W | Running counts from the counting engine, channel n at [16n+15:16n] |
| chan_out | input | 3 | Output level of each channel |
| load_pulse | output | 3 | One-cycle load strobe per channel |
| load_val | output | 3*2*BYTE_W | Start value per channel |
| chan_mode | output | 9 | Programmed mode per channel, 3 bits each |
| chan_bcd | output | 3 | BCD flag per channel |
| gate | output | 3 | Gate per channel |
| aux_wr | input | 1 | Auxiliary port write strobe |
| aux_wdata | input | 2 | Auxiliary write data: bit 1 speaker, bit 0 gate 2 |
| aux_rdata | output | BYTE_W | Auxiliary read data |
| spk_en | output | 1 | Speaker enable flag |

## Verification
The hardest state to reach from the ports is a channel holding status and count snapshots at the same time while its live sequencer sits mid-word. Only a read-back command can create that state, and the three kinds of data must then be drained in a fixed order. The stimulus first programs different byte orders and modes on each channel. It then issues read-back bytes that select two channels and both latch kinds at once. The live counts are changed between the latch command and the reads, so a snapshot returning the wrong value shows up as a mismatch. A half-finished word write followed by reprogramming checks that the sequencer rewinds.

// File: rtl/tmr_pkg.sv
// Shared constants and helpers for the timer register front end.
// Assumes a byte-wide bus and three channels.
package tmr_pkg;
    localparam int NCH = 3;

    // Byte-order field codes; 0 doubles as "no snapshot pending".
    localparam logic [1:0] ORD_NONE = 2'd0;
    localparam logic [1:0] ORD_LO   = 2'd1;
    localparam logic [1:0] ORD_HI   = 2'd2;
    localparam logic [1:0] ORD_WORD = 2'd3;

    // Fold the two alias mode codes onto their base modes.
    function automatic logic [2:0] fold_mode(input logic [2:0] m);
        return (m > 3'd5) ? (m - 3'd4) : m;
    endfunction
endpackage

// File: rtl/tmr_cmd_decode.sv
// Control-byte decoder: turns a write to the control port into per-channel
// program, count-latch and status-latch strobes. Purely combinational.
// Assumes at most one bus operation per cycle.
module tmr_cmd_decode
    import tmr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              ctl_wr,
    input  logic [BYTE_W-1:0] cbyte,
    output logic [NCH-1:0]    prog_stb,
    output logic [NCH-1:0]    cnt_latch_stb,
    output logic [NCH-1:0]    sts_latch_stb
);
    logic [1:0] sel;
    logic [1:0] ord;
    logic       is_rb;

    // Field extraction from the control byte.
    always_comb begin
        sel   = cbyte[7:6];
        ord   = cbyte[5:4];
        is_rb = (sel == 2'd3);
    end

    genvar ch;
    generate
        for (ch = 0; ch < NCH; ch++) begin : g_ch
            logic hit;
            logic rb_hit;
            // Per-channel strobe generation.
            always_comb begin
                hit               = ctl_wr && !is_rb && (sel == 2'(ch));
                rb_hit            = ctl_wr && is_rb && cbyte[ch+1];
                prog_stb[ch]      = hit && (ord != ORD_NONE);
                cnt_latch_stb[ch] = (hit && (ord == ORD_NONE)) || (rb_hit && !cbyte[5]);
                sts_latch_stb[ch] = rb_hit && !cbyte[4];
            end
        end
    endgenerate
endmodule

// File: rtl/tmr_chan_regs.sv
// Per-channel register set: mode, byte order, BCD flag, write and read byte
// sequencers, count and status snapshots, and the load strobe to the counter.
// Assumes program, latch and data strobes for one channel never coincide
// except the two latch strobes of a read-back command.
module tmr_chan_regs
    import tmr_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_stb,
    input  logic [1:0]        prog_ord,
    input  logic [2:0]        prog_mode,
    input  logic              prog_bcd,
    input  logic              cnt_latch_stb,
    input  logic              sts_latch_stb,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic [CNT_W-1:0]  live,
    input  logic              out_lvl,
    output logic [BYTE_W-1:0] rbyte,
    output logic [2:0]        mode,
    output logic              bcd,
    output logic              load_pulse,
    output logic [CNT_W-1:0]  load_val
);
    logic [1:0]        ord;
    logic              wr_hi;
    logic              rd_hi;
    logic [BYTE_W-1:0] hold;
    logic [1:0]        snap_ord;
    logic [CNT_W-1:0]  snap;
    logic              sts_pend;
    logic [BYTE_W-1:0] sts;

    // Register update: programming, latching, write sequencing, read side effects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ord        <= ORD_LO;
            mode       <= 3'd0;
            bcd        <= 1'b0;
            wr_hi      <= 1'b0;
            rd_hi      <= 1'b0;
            hold       <= '0;
            snap_ord   <= ORD_NONE;
            snap       <= '0;
            sts_pend   <= 1'b0;
            sts        <= '0;
            load_val   <= '0;
            load_pulse <= 1'b1;
        end else begin
            load_pulse <= 1'b0;
            if (prog_stb) begin
                ord   <= prog_ord;
                mode  <= fold_mode(prog_mode);
                bcd   <= prog_bcd;
                wr_hi <= 1'b0;
                rd_hi <= 1'b0;
            end
            if (cnt_latch_stb && (snap_ord == ORD_NONE)) begin
                snap     <= live;
                snap_ord <= ord;
            end
            if (sts_latch_stb && !sts_pend) begin
                sts      <= {out_lvl, 1'b0, ord, mode, bcd};
                sts_pend <= 1'b1;
            end
            if (wr_stb) begin
                case (ord)
                    ORD_LO: begin
                        load_val   <= {{BYTE_W{1'b0}}, wbyte};
                        load_pulse <= 1'b1;
                    end
                    ORD_HI: begin
                        load_val   <= {wbyte, {BYTE_W{1'b0}}};
                        load_pulse <= 1'b1;
                    end
                    ORD_WORD: begin
                        if (!wr_hi) begin
                            hold  <= wbyte;
                            wr_hi <= 1'b1;
                        end else begin
                            load_val   <= {wbyte, hold};
                            load_pulse <= 1'b1;
                            wr_hi      <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
            if (rd_stb) begin
                if (sts_pend) begin
                    sts_pend <= 1'b0;
                end else if (snap_ord != ORD_NONE) begin
                    snap_ord <= (snap_ord == ORD_WORD) ? ORD_HI : ORD_NONE;
                end else if (ord == ORD_WORD) begin
                    rd_hi <= ~rd_hi;
                end
            end
        end
    end

    // Read byte selection by priority: status, snapshot, live count.
    always_comb begin
        if (sts_pend) begin
            rbyte = sts;
        end else if (snap_ord != ORD_NONE) begin
            rbyte = (snap_ord == ORD_HI) ? snap[CNT_W-1:BYTE_W] : snap[BYTE_W-1:0];
        end else begin
            case (ord)
                ORD_HI:   rbyte = live[CNT_W-1:BYTE_W];
                ORD_WORD: rbyte = rd_hi ? live[CNT_W-1:BYTE_W] : live[BYTE_W-1:0];
                default:  rbyte = live[BYTE_W-1:0];
            endcase
        end
    end
endmodule

// File: rtl/tmr_aux_port.sv
// Auxiliary port: holds channel 2's gate and the speaker flag, runs the
// free-running refresh toggle and assembles the auxiliary read byte.
// Assumes BYTE_W of at least 6.
module tmr_aux_port #(
    parameter int BYTE_W       = 8,
    parameter int REFRESH_LOG2 = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aux_wr,
    input  logic [1:0]        aux_wdata,
    input  logic              out2,
    output logic              gate2,
    output logic              spk_en,
    output logic [BYTE_W-1:0] aux_rdata
);
    logic [REFRESH_LOG2:0] ref_cnt;

    // Gate and speaker flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate2  <= 1'b0;
            spk_en <= 1'b0;
        end else if (aux_wr) begin
            gate2  <= aux_wdata[0];
            spk_en <= aux_wdata[1];
        end
    end

    // Free-running refresh counter; its top bit is the toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_cnt <= '0;
        else        ref_cnt <= ref_cnt + 1'b1;
    end

    // Auxiliary read byte assembly.
    always_comb begin
        aux_rdata = BYTE_W'({2'b00, out2, ref_cnt[REFRESH_LOG2], 2'b00, spk_en, gate2});
    end
endmodule

// File: rtl/timer_bus_front.sv
// Top of the timer register front end: address decode, three channel
// register sets, the auxiliary port and the read-data multiplexer.
// Assumes wr_en and rd_en are never high in the same cycle.
module timer_bus_front
    import tmr_pkg::*;
#(
    parameter int BYTE_W       = 8,
    parameter int REFRESH_LOG2 = 14,
    localparam int CNT_W       = 2 * BYTE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [1:0]            addr,
    input  logic [BYTE_W-1:0]     wdata,
    output logic [BYTE_W-1:0]     rdata,
    input  logic [NCH*CNT_W-1:0]  live_count,
    input  logic [NCH-1:0]        chan_out,
    output logic [NCH-1:0]        load_pulse,
    output logic [NCH*CNT_W-1:0]  load_val,
    output logic [NCH*3-1:0]      chan_mode,
    output logic [NCH-1:0]        chan_bcd,
    output logic [NCH-1:0]        gate,
    input  logic                  aux_wr,
    input  logic [1:0]            aux_wdata,
    output logic [BYTE_W-1:0]     aux_rdata,
    output logic                  spk_en
);
    logic              ctl_wr;
    logic [NCH-1:0]    prog_stb;
    logic [NCH-1:0]    cnt_latch_stb;
    logic [NCH-1:0]    sts_latch_stb;
    logic [BYTE_W-1:0] rbyte [NCH];
    logic              gate2;

    // Control port write detection.
    always_comb ctl_wr = wr_en && (addr == 2'd3);

    tmr_cmd_decode #(.BYTE_W(BYTE_W)) u_dec (
        .ctl_wr        (ctl_wr),
        .cbyte         (wdata),
        .prog_stb      (prog_stb),
        .cnt_latch_stb (cnt_latch_stb),
        .sts_latch_stb (sts_latch_stb)
    );

    genvar ch;
    generate
        for (ch = 0; ch < NCH; ch++) begin : g_chan
            logic wr_hit;
            logic rd_hit;
            // Data port hit for this channel.
            always_comb begin
                wr_hit = wr_en && (addr == 2'(ch));
                rd_hit = rd_en && (addr == 2'(ch));
            end
            tmr_chan_regs #(.BYTE_W(BYTE_W)) u_chan (
                .clk           (clk),
                .rst_n         (rst_n),
                .prog_stb      (prog_stb[ch]),
                .prog_ord      (wdata[5:4]),
                .prog_mode     (wdata[3:1]),
                .prog_bcd      (wdata[0]),
                .cnt_latch_stb (cnt_latch_stb[ch]),
                .sts_latch_stb (sts_latch_stb[ch]),
                .wr_stb        (wr_hit),
                .rd_stb        (rd_hit),
                .wbyte         (wdata),
                .live          (live_count[ch*CNT_W +: CNT_W]),
                .out_lvl       (chan_out[ch]),
                .rbyte         (rbyte[ch]),
                .mode          (chan_mode[ch*3 +: 3]),
                .bcd           (chan_bcd[ch]),
                .load_pulse    (load_pulse[ch]),
                .load_val      (load_val[ch*CNT_W +: CNT_W])
            );
        end
    endgenerate

    tmr_aux_port #(.BYTE_W(BYTE_W), .REFRESH_LOG2(REFRESH_LOG2)) u_aux (
        .clk       (clk),
        .rst_n     (rst_n),
        .aux_wr    (aux_wr),
        .aux_wdata (aux_wdata),
        .out2      (chan_out[2]),
        .gate2     (gate2),
        .spk_en    (spk_en),
        .aux_rdata (aux_rdata)
    );

    // Gate outputs: channels 0 and 1 tied high, channel 2 from the auxiliary port.
    always_comb gate = {gate2, 2'b11};

    // Read data multiplexer; the control port reads as zero.
    always_comb begin
        case (addr)
            2'd0:    rdata = rbyte[0];
            2'd1:    rdata = rbyte[1];
            2'd2:    rdata = rbyte[2];
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/timer_bus_front_chk.sv
// Assertion checker for the timer register front end, bound to the top.
module timer_bus_front_chk #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic [2:0]       load_pulse,
    input logic [3*CNT_W-1:0] load_val,
    input logic [8:0]       chan_mode,
    input logic [2:0]       gate,
    input logic             aux_wr,
    input logic [1:0]       aux_wdata
);
    // R3: a control write never causes a load.
    p_ctl_no_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd3) |=> (load_pulse == 3'b000));

    // R3: a control write leaves every start value unchanged.
    p_ctl_keeps_val_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd3) |=> $stable(load_val));

    // R3: outside the reset-exit cycle at most one channel loads per cycle.
    p_one_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $onehot0(load_pulse));

    // R2: alias mode codes never reach the counting engine.
    p_mode_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_mode[2:0] <= 3'd5) && (chan_mode[5:3] <= 3'd5) && (chan_mode[8:6] <= 3'd5));

    // R9: channel 2's gate follows the last auxiliary write.
    p_gate2_aux_r9: assert property (@(posedge clk) disable iff (!rst_n)
        aux_wr |=> (gate[2] == $past(aux_wdata[0])));
endmodule

bind timer_bus_front timer_bus_front_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .load_pulse (load_pulse),
    .load_val   (load_val),
    .chan_mode  (chan_mode),
    .gate       (gate),
    .aux_wr     (aux_wr),
    .aux_wdata  (aux_wdata)
);

// File: tb/timer_bus_front_test.sv
module timer_bus_front_test;
    localparam int RLOG = 4;
    localparam int NV   = 27;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic [47:0] live_count;
    logic [2:0]  chan_out = 3'b101;
    logic [2:0]  load_pulse;
    logic [47:0] load_val;
    logic [8:0]  chan_mode;
    logic [2:0]  chan_bcd;
    logic [2:0]  gate;
    logic        aux_wr = 1'b0;
    logic [1:0]  aux_wdata = 2'b00;
    logic [7:0]  aux_rdata;
    logic        spk_en;

    int nchk  = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    timer_bus_front #(.BYTE_W(8), .REFRESH_LOG2(RLOG)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .live_count(live_count), .chan_out(chan_out),
        .load_pulse(load_pulse), .load_val(load_val), .chan_mode(chan_mode),
        .chan_bcd(chan_bcd), .gate(gate), .aux_wr(aux_wr), .aux_wdata(aux_wdata),
        .aux_rdata(aux_rdata), .spk_en(spk_en)
    );

    // Vector: {req[3:0], kind[1:0], addr[1:0], data[7:0], exp[15:0]}
    // kind 0 = control/data write, 1 = read and compare, 2 = write expecting a load, 3 = write expecting none
    localparam logic [31:0] VEC [NV] = '{
        {4'd2,  2'd0, 2'd3, 8'h30, 16'h0000}, // R2 ch0 word order, mode 0
        {4'd3,  2'd3, 2'd0, 8'h34, 16'h0000}, // R3 first byte held
        {4'd3,  2'd2, 2'd0, 8'h12, 16'h1234}, // R3 word load
        {4'd2,  2'd0, 2'd3, 8'h56, 16'h0000}, // R2 ch1 low-only, mode 3
        {4'd3,  2'd2, 2'd1, 8'h77, 16'h0077}, // R3 low-only load
        {4'd2,  2'd0, 2'd3, 8'h9E, 16'h0000}, // R2 ch2 mode code 7
        {4'd2,  2'd0, 2'd3, 8'hA0, 16'h0000}, // R2 ch2 high-only, mode 0
        {4'd3,  2'd2, 2'd2, 8'h5C, 16'h5C00}, // R3 high-only load
        {4'd8,  2'd1, 2'd0, 8'h00, 16'h0034}, // R8 word live low
        {4'd8,  2'd1, 2'd0, 8'h00, 16'h0012}, // R8 word live high
        {4'd8,  2'd1, 2'd1, 8'h00, 16'h00CD}, // R8 low-only
        {4'd8,  2'd1, 2'd1, 8'h00, 16'h00CD}, // R8 low-only again
        {4'd8,  2'd1, 2'd2, 8'h00, 16'h005A}, // R8 high-only
        {4'd5,  2'd0, 2'd3, 8'h00, 16'h0000}, // R5 latch ch0
        {4'd5,  2'd1, 2'd0, 8'h00, 16'h0034}, // R5 snapshot low
        {4'd5,  2'd1, 2'd0, 8'h00, 16'h0012}, // R5 snapshot high
        {4'd5,  2'd1, 2'd0, 8'h00, 16'h0034}, // R5 released, live low
        {4'd5,  2'd1, 2'd0, 8'h00, 16'h0012}, // R5 live high
        {4'd6,  2'd0, 2'd3, 8'hE2, 16'h0000}, // R6 status only, ch0
        {4'd7,  2'd1, 2'd0, 8'h00, 16'h00B0}, // R7 status byte ch0
        {4'd7,  2'd1, 2'd0, 8'h00, 16'h0034}, // R7 then live
        {4'd6,  2'd0, 2'd3, 8'hCC, 16'h0000}, // R6 ch1+ch2 count and status
        {4'd7,  2'd1, 2'd1, 8'h00, 16'h0016}, // R7 ch1 status first
        {4'd6,  2'd1, 2'd1, 8'h00, 16'h00CD}, // R6 ch1 count second
        {4'd7,  2'd1, 2'd2, 8'h00, 16'h00A0}, // R7 ch2 status
        {4'd6,  2'd1, 2'd2, 8'h00, 16'h005A}, // R6 ch2 count
        {4'd12, 2'd1, 2'd3, 8'h00, 16'h0000}  // R12 control port reads zero
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #2 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic aux_put(input logic [1:0] d);
        @(negedge clk);
        aux_wr = 1'b1; aux_wdata = d;
        @(negedge clk);
        aux_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog (all requirements): actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0] rb;
        live_count = {16'h5A0F, 16'hABCD, 16'h1234};

        // R11 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R11 load_pulse", 16'(load_pulse), 16'h0007);
        check("R11 load_val", 16'(load_val != 48'd0), 16'h0000);
        check("R11 gate", 16'(gate), 16'h0003);
        check("R11 mode/bcd", 16'({chan_mode, chan_bcd}), 16'h0000);
        check("R11 aux_rdata", 16'(aux_rdata), 16'h0020);
        check("R11 spk_en", 16'(spk_en), 16'h0000);
        // R10 refresh toggle after 2^RLOG cycles
        repeat (15) @(posedge clk);
        #1 check("R10 refresh before", 16'(aux_rdata[4]), 16'h0000);
        check("R11 load_pulse cleared", 16'(load_pulse), 16'h0000);
        @(posedge clk);
        #1 check("R10 refresh after", 16'(aux_rdata[4]), 16'h0001);
        repeat (16) @(posedge clk);
        #1 check("R10 refresh back", 16'(aux_rdata[4]), 16'h0000);

        // Table of vectors
        for (int i = 0; i < NV; i++) begin
            logic [3:0]  rq;
            logic [1:0]  kd;
            logic [1:0]  ad;
            logic [7:0]  dt;
            logic [15:0] ex;
            string       tg;
            {rq, kd, ad, dt, ex} = VEC[i];
            tg = $sformatf("R%0d vector %0d", rq, i);
            case (kd)
                2'd0: bus_wr(ad, dt);
                2'd1: begin
                    bus_rd(ad, rb);
                    check(tg, 16'(rb), ex);
                end
                2'd2: begin
                    bus_wr(ad, dt);
                    check(tg, 16'(load_pulse), 16'(3'b001 << ad));
                    check(tg, load_val[ad*16 +: 16], ex);
                end
                default: begin
                    bus_wr(ad, dt);
                    check(tg, 16'(load_pulse), 16'h0000);
                end
            endcase
        end

        // R4 rewind of a half-written word
        bus_wr(2'd3, 8'h30);
        bus_wr(2'd0, 8'hAA);
        bus_wr(2'd3, 8'h30);
        bus_wr(2'd0, 8'h11);
        check("R4 first byte after rewind", 16'(load_pulse), 16'h0000);
        bus_wr(2'd0, 8'h22);
        check("R4 load after rewind", load_val[15:0], 16'h2211);

        // R5 snapshot and ignored repeat latch
        bus_wr(2'd3, 8'h00);
        live_count[15:0] = 16'h5678;
        bus_wr(2'd3, 8'h00);
        bus_rd(2'd0, rb); check("R5 snapshot low", 16'(rb), 16'h0034);
        bus_rd(2'd0, rb); check("R5 snapshot high", 16'(rb), 16'h0012);
        bus_rd(2'd0, rb); check("R5 live low", 16'(rb), 16'h0078);
        bus_rd(2'd0, rb); check("R5 live high", 16'(rb), 16'h0056);

        // R2 mode folding and BCD
        bus_wr(2'd3, 8'h7D);
        check("R2 ch1 mode 6 folds to 2", 16'(chan_mode[5:3]), 16'h0002);
        check("R2 ch1 bcd", 16'(chan_bcd[1]), 16'h0001);
        bus_wr(2'd3, 8'h1E);
        check("R2 ch0 mode 7 folds to 3", 16'(chan_mode[2:0]), 16'h0003);

        // R6 read-back touches only the selected channel; R1 select
        bus_wr(2'd3, 8'hD2);
        live_count[15:0]  = 16'h9999;
        live_count[31:16] = 16'h1111;
        bus_rd(2'd0, rb); check("R6 ch0 latched", 16'(rb), 16'h0078);
        bus_rd(2'd0, rb); check("R6 ch0 live after", 16'(rb), 16'h0099);
        bus_rd(2'd1, rb); check("R1 ch1 unselected live", 16'(rb), 16'h0011);

        // R9 auxiliary port
        aux_put(2'b11);
        check("R9 gate2 set", 16'(gate), 16'h0007);
        check("R9 speaker", 16'(spk_en), 16'h0001);
        check("R9 aux read", 16'(aux_rdata & 8'hEF), 16'h0023);
        aux_put(2'b00);
        chan_out[2] = 1'b0;
        #1 check("R9 aux cleared", 16'(aux_rdata & 8'hEF), 16'h0000);
        check("R9 gate2 low", 16'(gate), 16'h0003);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule